// File: doc/BRIEF.md
# Two-Wire Controller Status and Interrupt Unit

This block holds the status flags and the interrupt request of a two-wire serial controller. The master and slave bus engines send it single-cycle event pulses:
- a byte landed in the receive holding register;
- the transmit shifter asks for its next byte;
- a frame began or ended;
- the far end did not acknowledge;
- arbitration was lost;
- the slave address or the general-call address matched, with the transfer direction.

The core side sends it pulses too: the receive holding register was read, the transmit holding register was written, the status word was read, and the master was enabled.

Each flag is sticky and has its own clearing rule. Receive overrun and transmit underrun are detected here, not in the engines. An underrun in master mode also raises a one-cycle request to the master engine to end the frame with a STOP. An interrupt mask has separate set and clear inputs and can be read back. A single interrupt line is raised whenever an enabled flag is high. Bus signalling is not part of this block.

Top module: `twi_status_unit`

## Requirements
- R1: After a synchronous active-low reset, the status word, the mask, the interrupt and the stop request are all zero. Status bit positions are: 0 frame done, 1 receive ready, 2 transmit ready, 3 slave read direction, 4 slave access, 5 general call, 6 overrun, 7 underrun, 8 no-acknowledge, 9 arbitration lost.
- R2: Receive ready (bit 1) sets when a byte is loaded and clears when the receive holding register is read. If both happen in the same cycle, the set wins.
- R3: Overrun (bit 6) sets when a byte is loaded while receive ready is already set and the holding register is not being read in that same cycle.
- R4: Transmit ready (bit 2) clears on a transmit holding write. It sets when a shifter request finds the holding register full (ready low), on no-acknowledge, and on master enable. A set wins over a write in the same cycle.
- R5: Frame done (bit 0) sets on frame end, on no-acknowledge, on arbitration lost and on master enable. It clears only on frame start, and a set wins over a clear.
- R6: A slave address match sets slave access (bit 4) and captures the direction input into bit 3. A general-call match sets bit 5. Bit 3 clears whenever slave access clears.
- R7: A status read clears bits 4, 5, 6, 7 and 3 only if frame done is set in that cycle. A set event in the same cycle wins.
- R8: No-acknowledge (bit 8) and arbitration lost (bit 9) become visible in the same cycle as frame done. Any status read clears them, unless a new event for the same flag arrives in that cycle.
- R9: A shifter request while transmit ready is set sets underrun (bit 7). In master mode, `auto_stop_o` is then high for exactly the following cycle. In slave mode it stays low.
- R10: Each one bit on `mask_set_i` sets that mask bit, and each one bit on `mask_clr_i` clears it. Zero bits leave the mask unchanged. If both inputs name the same bit, the set wins.
- R11: `irq_o` is high exactly when some status bit and the same mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master_i | input | 1 | Controller is operating as bus master |
| master_en_i | input | 1 | Pulse: master has been enabled |
| frame_start_i | input | 1 | Pulse: a frame has begun |
| frame_done_i | input | 1 | Pulse: a frame has ended |
| nack_i | input | 1 | Pulse: far end did not acknowledge |
| arb_lost_i | input | 1 | Pulse: arbitration lost |
| slv_match_i | input | 1 | Pulse: own slave address matched |
| gc_match_i | input | 1 | Pulse: general-call address matched |
| slv_dir_i | input | 1 | Direction of the match, 1 = read |
| rx_load_i | input | 1 | Pulse: byte loaded into receive holding register |
| rx_read_i | input | 1 | Pulse: receive holding register read |
| tx_write_i | input | 1 | Pulse: transmit holding register written |
| shift_req_i | input | 1 | Pulse: transmit shifter wants its next byte |
| status_rd_i | input | 1 | Pulse: status word read |
| mask_set_i | input | 10 | Mask bits to set |
| mask_clr_i | input | 10 | Mask bits to clear |
| status_o | output | 10 | Status flags |
| mask_o | output | 10 | Current interrupt mask |
| irq_o | output | 1 | Interrupt request |
| auto_stop_o | output | 1 | One-cycle request to end the frame with a STOP |

## Verification
Every flag and mask bit is registered. Its new value is visible one clock after the edge that samples the event, and `auto_stop_o` is high for the single cycle after that edge. `irq_o` is combinational from the registered flags and mask, so it changes in the same cycle they do. The bench drives every pulse on a falling edge and lets one rising edge pass. It then removes the pulse and compares all outputs at the following falling edge. Each check therefore sees exactly the state after one sampled event, and the `auto_stop_o` pulse is seen before it ends.

// File: rtl/twi_stat_pkg.sv
// Package: shared flag positions and types for the two-wire status unit.
// Assumes the status word layout is fixed by the software-visible encoding.
package twi_stat_pkg;
    localparam int NUM_FLAGS = 10;
    localparam int F_DONE  = 0;
    localparam int F_RXRDY = 1;
    localparam int F_TXRDY = 2;
    localparam int F_SDIR  = 3;
    localparam int F_SACC  = 4;
    localparam int F_GCALL = 5;
    localparam int F_OVR   = 6;
    localparam int F_UNR   = 7;
    localparam int F_NACK  = 8;
    localparam int F_ARB   = 9;
    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/twi_bus_flags.sv
// Module: bus-event flags (frame done, slave access, general call, direction,
// no-acknowledge, arbitration lost). Assumes every event input is a one-cycle
// pulse. Same-cycle set beats clear. Exports the gated status-read clear so
// that the transfer flags apply the same rule.
module twi_bus_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic master_en_i,
    input  logic frame_start_i,
    input  logic frame_done_i,
    input  logic nack_i,
    input  logic arb_lost_i,
    input  logic slv_match_i,
    input  logic gc_match_i,
    input  logic slv_dir_i,
    input  logic status_rd_i,
    output logic cond_clr_o,
    output logic done_o,
    output logic sdir_o,
    output logic sacc_o,
    output logic gcall_o,
    output logic nack_o,
    output logic arb_o
);
    logic done_q, sdir_q, sacc_q, gcall_q, nack_q, arb_q;
    logic done_set;

    // Frame done is set by any event that ends a frame, or by master enable.
    assign done_set   = frame_done_i | nack_i | arb_lost_i | master_en_i;
    // A status read clears the gated flags only while frame done is set.
    assign cond_clr_o = status_rd_i & done_q;

    // Frame done: set by end events, cleared only by frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)            done_q <= 1'b0;
        else if (done_set)     done_q <= 1'b1;
        else if (frame_start_i) done_q <= 1'b0;
    end

    // Slave access and the captured direction move together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sacc_q <= 1'b0;
            sdir_q <= 1'b0;
        end else if (slv_match_i) begin
            sacc_q <= 1'b1;
            sdir_q <= slv_dir_i;
        end else if (cond_clr_o) begin
            sacc_q <= 1'b0;
            sdir_q <= 1'b0;
        end
    end

    // General call: set by a match, cleared by a gated status read.
    always_ff @(posedge clk) begin
        if (!rst_n)          gcall_q <= 1'b0;
        else if (gc_match_i) gcall_q <= 1'b1;
        else if (cond_clr_o) gcall_q <= 1'b0;
    end

    // No-acknowledge and arbitration lost: cleared by any status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nack_q <= 1'b0;
            arb_q  <= 1'b0;
        end else begin
            if (nack_i)           nack_q <= 1'b1;
            else if (status_rd_i) nack_q <= 1'b0;
            if (arb_lost_i)       arb_q  <= 1'b1;
            else if (status_rd_i) arb_q  <= 1'b0;
        end
    end

    assign done_o  = done_q;
    assign sdir_o  = sdir_q;
    assign sacc_o  = sacc_q;
    assign gcall_o = gcall_q;
    assign nack_o  = nack_q;
    assign arb_o   = arb_q;

    // R8: a newly raised no-acknowledge always comes with frame done
    a_r8_nack_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_q) |-> done_q);
    // R8: a newly raised arbitration loss always comes with frame done
    a_r8_arb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_q) |-> done_q);
    // R7: a status read without frame done keeps slave access
    a_r7_keep_without_done: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd_i && !done_q && sacc_q) |=> sacc_q);
    // R6: the direction bit is never set without slave access
    a_r6_dir_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        sdir_q |-> sacc_q);
endmodule

// File: rtl/twi_xfer_flags.sv
// Module: data-path flags (receive ready, overrun, transmit ready, underrun)
// and the master STOP request on underrun. Assumes the transmit holding
// register is full exactly while transmit ready is low.
module twi_xfer_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic is_master_i,
    input  logic master_en_i,
    input  logic nack_i,
    input  logic rx_load_i,
    input  logic rx_read_i,
    input  logic tx_write_i,
    input  logic shift_req_i,
    input  logic cond_clr_i,
    output logic rxrdy_o,
    output logic ovr_o,
    output logic txrdy_o,
    output logic unr_o,
    output logic auto_stop_o
);
    logic rxrdy_q, ovr_q, txrdy_q, unr_q, stop_q;
    logic tx_move, tx_starve, ovr_hit, tx_set;

    // Classify a shifter request: data available, or starvation.
    assign tx_move   = shift_req_i & ~txrdy_q;
    assign tx_starve = shift_req_i &  txrdy_q;
    // A load overruns only if the unread byte is not taken in the same cycle.
    assign ovr_hit   = rx_load_i & rxrdy_q & ~rx_read_i;
    assign tx_set    = tx_move | nack_i | master_en_i;

    // Receive ready: set by a load, cleared by a holding-register read.
    always_ff @(posedge clk) begin
        if (!rst_n)         rxrdy_q <= 1'b0;
        else if (rx_load_i) rxrdy_q <= 1'b1;
        else if (rx_read_i) rxrdy_q <= 1'b0;
    end

    // Transmit ready: set on move, no-ack or enable; cleared by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)          txrdy_q <= 1'b0;
        else if (tx_set)     txrdy_q <= 1'b1;
        else if (tx_write_i) txrdy_q <= 1'b0;
    end

    // Error flags: sticky until a gated status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            unr_q <= 1'b0;
        end else begin
            if (ovr_hit)         ovr_q <= 1'b1;
            else if (cond_clr_i) ovr_q <= 1'b0;
            if (tx_starve)       unr_q <= 1'b1;
            else if (cond_clr_i) unr_q <= 1'b0;
        end
    end

    // One-cycle STOP request after a master-mode underrun.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_q <= 1'b0;
        else        stop_q <= tx_starve & is_master_i;
    end

    assign rxrdy_o     = rxrdy_q;
    assign ovr_o       = ovr_q;
    assign txrdy_o     = txrdy_q;
    assign unr_o       = unr_q;
    assign auto_stop_o = stop_q;

    // R3: a load onto an unread byte raises overrun
    a_r3_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load_i && rxrdy_q && !rx_read_i) |=> ovr_q);
    // R4: a holding write with no set source drops transmit ready
    a_r4_write_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_write_i && !shift_req_i && !nack_i && !master_en_i) |=> !txrdy_q);
    // R9: a request while ready raises underrun
    a_r9_underrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_req_i && txrdy_q) |=> unr_q);
    // R9: a STOP request only follows a master-mode cycle
    a_r9_stop_master_only: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |-> $past(is_master_i));
endmodule

// File: rtl/twi_irq_mask.sv
// Module: interrupt mask with bitwise set and clear inputs, and the
// interrupt reduction. Assumes both mask inputs are sampled every cycle.
module twi_irq_mask #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] flags_i,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    logic [W-1:0] mask_q;

    // One register per mask bit; a set beats a clear.
    for (genvar k = 0; k < W; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)        mask_q[k] <= 1'b0;
            else if (set_i[k]) mask_q[k] <= 1'b1;
            else if (clr_i[k]) mask_q[k] <= 1'b0;
        end
    end

    // Interrupt: any enabled flag.
    assign irq_o  = |(flags_i & mask_q);
    assign mask_o = mask_q;

    // R10: every bit written as one on the set input is set afterwards
    a_r10_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((mask_q & $past(set_i)) == $past(set_i)));
    // R10: a bit named by neither input keeps its value
    a_r10_untouched_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i | clr_i) == '0) |=> $stable(mask_q));
endmodule

// File: rtl/twi_status_unit.sv
// Module: top of the two-wire status and interrupt unit. It assembles the
// status word from the bus-event and data-path flag blocks, then drives the
// mask and the interrupt line. Assumes all event inputs are one-cycle pulses
// synchronous to clk.
module twi_status_unit
    import twi_stat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 is_master_i,
    input  logic                 master_en_i,
    input  logic                 frame_start_i,
    input  logic                 frame_done_i,
    input  logic                 nack_i,
    input  logic                 arb_lost_i,
    input  logic                 slv_match_i,
    input  logic                 gc_match_i,
    input  logic                 slv_dir_i,
    input  logic                 rx_load_i,
    input  logic                 rx_read_i,
    input  logic                 tx_write_i,
    input  logic                 shift_req_i,
    input  logic                 status_rd_i,
    input  logic [NUM_FLAGS-1:0] mask_set_i,
    input  logic [NUM_FLAGS-1:0] mask_clr_i,
    output logic [NUM_FLAGS-1:0] status_o,
    output logic [NUM_FLAGS-1:0] mask_o,
    output logic                 irq_o,
    output logic                 auto_stop_o
);
    logic      cond_clr;
    logic      f_done, f_sdir, f_sacc, f_gcall, f_nack, f_arb;
    logic      f_rxrdy, f_ovr, f_txrdy, f_unr;
    flag_vec_t flags;

    twi_bus_flags u_bus (
        .clk(clk), .rst_n(rst_n), .master_en_i(master_en_i),
        .frame_start_i(frame_start_i), .frame_done_i(frame_done_i),
        .nack_i(nack_i), .arb_lost_i(arb_lost_i), .slv_match_i(slv_match_i),
        .gc_match_i(gc_match_i), .slv_dir_i(slv_dir_i),
        .status_rd_i(status_rd_i), .cond_clr_o(cond_clr),
        .done_o(f_done), .sdir_o(f_sdir), .sacc_o(f_sacc),
        .gcall_o(f_gcall), .nack_o(f_nack), .arb_o(f_arb)
    );

    twi_xfer_flags u_xfer (
        .clk(clk), .rst_n(rst_n), .is_master_i(is_master_i),
        .master_en_i(master_en_i), .nack_i(nack_i), .rx_load_i(rx_load_i),
        .rx_read_i(rx_read_i), .tx_write_i(tx_write_i),
        .shift_req_i(shift_req_i), .cond_clr_i(cond_clr),
        .rxrdy_o(f_rxrdy), .ovr_o(f_ovr), .txrdy_o(f_txrdy), .unr_o(f_unr),
        .auto_stop_o(auto_stop_o)
    );

    // Place each flag at its software-visible bit position.
    always_comb begin
        flags          = '0;
        flags[F_DONE]  = f_done;
        flags[F_RXRDY] = f_rxrdy;
        flags[F_TXRDY] = f_txrdy;
        flags[F_SDIR]  = f_sdir;
        flags[F_SACC]  = f_sacc;
        flags[F_GCALL] = f_gcall;
        flags[F_OVR]   = f_ovr;
        flags[F_UNR]   = f_unr;
        flags[F_NACK]  = f_nack;
        flags[F_ARB]   = f_arb;
    end

    twi_irq_mask #(.W(NUM_FLAGS)) u_mask (
        .clk(clk), .rst_n(rst_n), .set_i(mask_set_i), .clr_i(mask_clr_i),
        .flags_i(flags), .mask_o(mask_o), .irq_o(irq_o)
    );

    assign status_o = flags;

    // R11: with an empty mask the interrupt line stays low
    a_r11_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '0) |-> !irq_o);
    // R1: the cycle after reset everything is clear
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (status_o == '0 && mask_o == '0 && !auto_stop_o));
endmodule

// File: tb/sim_twi_status_unit.sv
module sim_twi_status_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 31;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [13:0] stim = '0;
    logic [9:0] mset = '0, mclr = '0;
    logic [9:0] status, mask;
    logic       irq, astop;
    int         n_checks = 0, n_fail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // stim bits: 0 frame start, 1 frame done, 2 rx load, 3 rx read, 4 tx write,
    // 5 shift request, 6 nack, 7 arb lost, 8 slave match, 9 gc match,
    // 10 slave dir, 11 master enable, 12 status read, 13 is master
    twi_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .is_master_i(stim[13]),
        .master_en_i(stim[11]), .frame_start_i(stim[0]),
        .frame_done_i(stim[1]), .nack_i(stim[6]), .arb_lost_i(stim[7]),
        .slv_match_i(stim[8]), .gc_match_i(stim[9]), .slv_dir_i(stim[10]),
        .rx_load_i(stim[2]), .rx_read_i(stim[3]), .tx_write_i(stim[4]),
        .shift_req_i(stim[5]), .status_rd_i(stim[12]),
        .mask_set_i(mset), .mask_clr_i(mclr), .status_o(status),
        .mask_o(mask), .irq_o(irq), .auto_stop_o(astop)
    );

    // {requirement, expected stop, expected status, stimulus}
    localparam logic [28:0] VEC [NV] = '{
        {4'd5, 1'b0, 10'h005, 14'h0800},  // R5 master enable: done + tx ready
        {4'd4, 1'b0, 10'h001, 14'h0010},  // R4 holding write drops ready
        {4'd5, 1'b0, 10'h000, 14'h0001},  // R5 frame start clears done
        {4'd4, 1'b0, 10'h004, 14'h2020},  // R4 request with full holding: moved
        {4'd9, 1'b1, 10'h084, 14'h2020},  // R9 request while empty: underrun + stop
        {4'd7, 1'b0, 10'h084, 14'h1000},  // R7 read without done keeps underrun
        {4'd5, 1'b0, 10'h085, 14'h0002},  // R5 frame end
        {4'd7, 1'b0, 10'h005, 14'h1000},  // R7 read with done clears underrun
        {4'd2, 1'b0, 10'h007, 14'h0004},  // R2 byte loaded
        {4'd3, 1'b0, 10'h047, 14'h0004},  // R3 second load: overrun
        {4'd2, 1'b0, 10'h045, 14'h0008},  // R2 read clears ready
        {4'd2, 1'b0, 10'h047, 14'h000C},  // R2 load + read: set wins
        {4'd7, 1'b0, 10'h007, 14'h1000},  // R7 read clears overrun
        {4'd3, 1'b0, 10'h007, 14'h000C},  // R3 load + read while ready: no overrun
        {4'd2, 1'b0, 10'h005, 14'h0008},  // R2 read clears ready
        {4'd5, 1'b0, 10'h004, 14'h0001},  // R5 frame start
        {4'd6, 1'b0, 10'h01C, 14'h0500},  // R6 match, read direction
        {4'd7, 1'b0, 10'h01C, 14'h1000},  // R7 read without done keeps access
        {4'd6, 1'b0, 10'h03C, 14'h0200},  // R6 general call
        {4'd5, 1'b0, 10'h03D, 14'h0002},  // R5 frame end
        {4'd6, 1'b0, 10'h005, 14'h1000},  // R6 access, gc and direction clear
        {4'd4, 1'b0, 10'h000, 14'h0011},  // R4 write + frame start
        {4'd8, 1'b0, 10'h105, 14'h0040},  // R8 nack: done, tx ready, nack
        {4'd8, 1'b0, 10'h005, 14'h1000},  // R8 any read clears nack
        {4'd5, 1'b0, 10'h004, 14'h0001},  // R5 frame start
        {4'd8, 1'b0, 10'h205, 14'h0080},  // R8 arb lost with done
        {4'd8, 1'b0, 10'h205, 14'h1080},  // R8 read + arb: set wins
        {4'd8, 1'b0, 10'h005, 14'h1000},  // R8 read clears arb
        {4'd6, 1'b0, 10'h015, 14'h0100},  // R6 match, write direction
        {4'd7, 1'b0, 10'h015, 14'h1100},  // R7 read + match: set wins
        {4'd7, 1'b0, 10'h005, 14'h1000}   // R7 read clears access
    };

    task automatic chk(input string what, input logic [9:0] act, input logic [9:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %03h expected %03h", what, act, exp);
        end
    endtask

    // Apply one stimulus for one rising edge, then sample at the falling edge.
    task automatic apply(input logic [13:0] s, input logic [9:0] ms, input logic [9:0] mc);
        stim = s; mset = ms; mclr = mc;
        @(posedge clk);
        @(negedge clk);
        stim = '0; mset = '0; mclr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 status after reset", status, 10'h000);
        chk("R1 mask after reset", mask, 10'h000);
        chk("R1 irq/stop after reset", {8'h0, irq, astop}, 10'h000);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][13:0], '0, '0);
            chk($sformatf("R%0d vector %0d status", VEC[i][28:25], i), status, VEC[i][23:14]);
            chk($sformatf("R%0d vector %0d stop", VEC[i][28:25], i), {9'h0, astop}, {9'h0, VEC[i][24]});
        end

        // R10 / R11: status is 0x005 here
        apply('0, 10'h006, '0);
        chk("R10 mask set", mask, 10'h006);
        chk("R11 irq on enabled tx ready", {9'h0, irq}, 10'h001);
        apply('0, '0, 10'h004);
        chk("R10 mask clear one bit", mask, 10'h002);
        chk("R11 irq low when enabled flag is low", {9'h0, irq}, 10'h000);
        apply('0, 10'h300, 10'h302);
        chk("R10 set beats clear", mask, 10'h300);
        apply(14'h0080, '0, '0);
        chk("R11 irq on arb lost", {9'h0, irq}, 10'h001);
        apply(14'h1000, '0, '0);
        chk("R11 irq drops after read", {9'h0, irq}, 10'h000);

        // R9 underrun in slave mode: flag but no stop
        apply(14'h0020, '0, '0);
        chk("R9 slave underrun status", status, 10'h085);
        chk("R9 no stop in slave mode", {9'h0, astop}, 10'h000);

        // R1 reset in mid-run
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk("R1 status after second reset", status, 10'h000);
        chk("R1 mask after second reset", mask, 10'h000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule